// File: doc/BRIEF.md
# Generalized Hebbian Learning Engine

This block trains a small weight matrix with the generalized Hebbian rule, also known as Sanger's rule. The matrix has M rows, one for each output neuron, and N columns, one for each input, with M < N. Training vectors arrive one at a time on a valid/ready stream. For each vector the block first computes the outputs y = C·x from the weights as they stood before the vector arrived. It then rewrites every weight as C + η·(y·xᵀ − LT[y·yᵀ]·C). LT keeps the diagonal and the entries below it and clears the entries above it. This term makes the rows converge to ordered principal components, where a plain Hebbian rule would only accumulate y·xᵀ.

Every value is signed Q4.12 (16 bits, 12 fractional bits). Sums are carried in a wide accumulator, and each result saturates to the 16-bit range. The learning rate is a power of two given as a right-shift amount.

A host loads the starting weights through a write port while the block is idle. It streams vectors in, waits for the `done` pulse, and reads the outputs and weights through combinational read ports.

A single shared multiply datapath works through the matrix in two passes:
- a row-wise pass that builds y;
- a column-wise pass that updates the weights.

Within a column, the running sum Σ_{k≤i} y[k]·C[k][j] is built from old values before each weight is written back. No shadow copy of the matrix is needed.

Top module: `gha_engine`

## Requirements
- R1: After reset, and after any later reset, `s_ready` is 1, `done` is 0, every weight reads 0 and every output reads 0.
- R2: When `wr_en` is high while the block is idle (ready, with no element of a vector yet accepted), `wr_data` is stored at (`wr_row`, `wr_col`). The value is readable on `rd_weight` once the next clock edge has passed.
- R3: A weight write is ignored when it is requested after the first element of a vector has been accepted and before `done`. This holds while elements are still arriving and during the computation.
- R4: A vector ends at the handshake of its N-th element, or earlier at a handshake with `s_last` high. From the cycle after that handshake, `s_ready` stays 0 until the update is complete.
- R5: When `s_last` ends a vector early, the inputs that were not sent are taken as zero, whatever earlier vectors carried.
- R6: Output i equals sat(floor(Σ_j C[i][j]·x[j] / 4096)), computed with the weights held before the vector. It is read on `y_out` with `y_sel` = i.
- R7: Each weight becomes sat(C + floor(y[i]·e / 2^(12+s))), where e = sat(floor((x[j]·4096 − Σ_{k≤i} y[k]·C[k][j]) / 4096)) and s is the learning-rate shift. Only old weights are used on the right-hand side.
- R8: The learning-rate shift is sampled from `lr_shift` at the handshake of a vector's first element. Later changes within the same vector have no effect.
- R9: Every output and every weight saturates to the range −32768 to 32767 instead of wrapping.
- R10: `done` is high for exactly one cycle when the update finishes. `s_ready` is high in that same cycle.
- R11: While the block waits for a vector, outputs do not change. Weights change only through R2 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input element valid |
| s_ready | output | 1 | Block can accept an input element |
| s_data | input | 16 | Input element, Q4.12 |
| s_last | input | 1 | Marks the final element of a vector |
| lr_shift | input | 4 | Learning rate as a right shift, η = 2^-shift |
| wr_en | input | 1 | Weight write request |
| wr_row | input | $clog2(M) | Weight write row |
| wr_col | input | $clog2(N) | Weight write column |
| wr_data | input | 16 | Weight write value, Q4.12 |
| rd_row | input | $clog2(M) | Weight read row |
| rd_col | input | $clog2(N) | Weight read column |
| rd_weight | output | 16 | Weight at (rd_row, rd_col), 0 when out of range |
| y_sel | input | $clog2(M) | Output index to read |
| y_out | output | 16 | Output y[y_sel] from the latest vector |
| done | output | 1 | One-cycle pulse when an update has finished |

## Verification
Errors in the state held inside the block show up at the ports only after `done`.

- A corrupted running column sum, a wrong triangular bound, or a weight written back before a later row has used it leaves no trace until `done`. At that point the weights read back differ from the exact integer model in the rows below the row where the error began.
- A stale input element, left over from an earlier vector, shows up in the same way after a vector that `s_last` ended early.
- A wrong shift sample or a missing saturation makes every weight after that vector diverge.

Sequencing faults show up sooner:
- `s_ready` staying high after the last handshake;
- `done` lasting more than one cycle;
- the outputs moving while the block is idle.

These show up within one cycle of the event and are caught there.

// File: rtl/gha_pkg.sv
`timescale 1ns/1ps
// Shared number format, phase encoding and saturation helper for the
// generalized Hebbian engine. Assumes a two's-complement Q4.12 format.
package gha_pkg;
    localparam int DW   = 16;  // data width of x, y and weights
    localparam int FRAC = 12;  // fractional bits
    localparam int SHW  = 4;   // width of the learning-rate shift

    localparam logic signed [63:0] QMAX = (64'sd1 <<< (DW - 1)) - 64'sd1;
    localparam logic signed [63:0] QMIN = -(64'sd1 <<< (DW - 1));

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,  // collecting the input vector
        PH_OUT  = 2'd1,  // computing y row by row
        PH_UPD  = 2'd2   // rewriting weights column by column
    } phase_t;

    // Clamp a wide signed value into the DW-bit data range.
    function automatic logic signed [DW-1:0] sat_dw(input logic signed [63:0] v);
        if (v > QMAX)      return DW'(QMAX);
        else if (v < QMIN) return DW'(QMIN);
        else               return DW'(v);
    endfunction
endpackage

// File: rtl/gha_weight_store.sv
`timescale 1ns/1ps
// Register array holding the M x N weight matrix.
// One write port, one engine read port (its address is always in range) and
// one guarded host read port. Writes to out-of-range addresses are dropped.
module gha_weight_store
    import gha_pkg::*;
#(
    parameter int M  = 2,
    parameter int N  = 5,
    parameter int RW = 1,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [RW-1:0]        wrow,
    input  logic [CW-1:0]        wcol,
    input  logic signed [DW-1:0] wdata,
    input  logic [RW-1:0]        arow,
    input  logic [CW-1:0]        acol,
    output logic signed [DW-1:0] adata,
    input  logic [RW-1:0]        brow,
    input  logic [CW-1:0]        bcol,
    output logic signed [DW-1:0] bdata,
    output logic [M*N*DW-1:0]    w_flat
);
    logic signed [DW-1:0] mem [M][N];
    logic w_ok;

    // Only in-range addresses may be written.
    assign w_ok = we && (32'(wrow) < M) && (32'(wcol) < N);

    // Clear on reset; otherwise take one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < M; r++)
                for (int c = 0; c < N; c++)
                    mem[r][c] <= '0;
        end else if (w_ok) begin
            mem[wrow][wcol] <= wdata;
        end
    end

    // Engine read port.
    assign adata = mem[arow][acol];

    // Host read port, zero when the address is out of range.
    assign bdata = ((32'(brow) < M) && (32'(bcol) < N)) ? mem[brow][bcol] : '0;

    // Flat view of the matrix for the bound checker.
    for (genvar r = 0; r < M; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            assign w_flat[(r*N + c)*DW +: DW] = mem[r][c];
        end
    end
endmodule

// File: rtl/gha_lane_math.sv
`timescale 1ns/1ps
// Combinational single-weight update step of the Sanger rule.
// Given y[i], the old C[i][j], x[j] and the running column sum of
// y[k]*C[k][j] for k < i, it returns the sum extended by row i and the
// saturated new weight. Assumes AW leaves headroom for M products.
module gha_lane_math
    import gha_pkg::*;
#(
    parameter int AW = 40
) (
    input  logic signed [DW-1:0] y_i,
    input  logic signed [DW-1:0] c_old,
    input  logic signed [DW-1:0] x_j,
    input  logic signed [AW-1:0] sum_in,
    input  logic [SHW-1:0]       shift,
    output logic signed [AW-1:0] sum_out,
    output logic signed [DW-1:0] c_new
);
    logic signed [2*DW-1:0] p_yc;
    logic signed [2*DW-1:0] p_ye;
    logic signed [AW-1:0]   resid;
    logic signed [DW-1:0]   err;
    logic signed [2*DW-1:0] delta;

    // Triangular sum, residual, Hebbian product and saturating write value.
    always_comb begin
        p_yc    = (2*DW)'(y_i) * (2*DW)'(c_old);
        sum_out = sum_in + AW'(p_yc);
        resid   = (AW'(x_j) <<< FRAC) - sum_out;
        err     = sat_dw(64'(resid >>> FRAC));
        p_ye    = (2*DW)'(y_i) * (2*DW)'(err);
        delta   = p_ye >>> (FRAC + 32'(shift));
        c_new   = sat_dw(64'(c_old) + 64'(delta));
    end
endmodule

// File: rtl/gha_engine.sv
`timescale 1ns/1ps
// Generalized Hebbian (Sanger) training engine, top level.
// Collects one N-element vector, computes y = C*x row by row (M*N cycles),
// then updates C column by column (M*N cycles), pulsing done at the end.
// Assumes M < N, Q4.12 data and AW wide enough for N products.
module gha_engine
    import gha_pkg::*;
#(
    parameter  int M  = 2,
    parameter  int N  = 5,
    parameter  int AW = 40,
    localparam int RW = (M > 1) ? $clog2(M) : 1,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic signed [DW-1:0] s_data,
    input  logic                 s_last,
    input  logic [SHW-1:0]       lr_shift,
    input  logic                 wr_en,
    input  logic [RW-1:0]        wr_row,
    input  logic [CW-1:0]        wr_col,
    input  logic signed [DW-1:0] wr_data,
    input  logic [RW-1:0]        rd_row,
    input  logic [CW-1:0]        rd_col,
    output logic signed [DW-1:0] rd_weight,
    input  logic [RW-1:0]        y_sel,
    output logic signed [DW-1:0] y_out,
    output logic                 done
);
    phase_t                phase_q;
    logic [CW-1:0]         in_cnt_q;
    logic [CW-1:0]         j_q;
    logic [RW-1:0]         i_q;
    logic signed [DW-1:0]  x_q [N];
    logic signed [DW-1:0]  y_q [M];
    logic signed [AW-1:0]  acc_q;
    logic signed [AW-1:0]  sum_q;
    logic [SHW-1:0]        shift_q;
    logic                  done_q;

    logic                  accept;
    logic                  vec_end;
    logic                  upd_we;
    logic                  host_we;
    logic signed [DW-1:0]  c_a;
    logic signed [DW-1:0]  c_new;
    logic signed [AW-1:0]  sum_nxt;
    logic signed [2*DW-1:0] mac_prod;
    logic signed [AW-1:0]  acc_nxt;
    logic [M*N*DW-1:0]     w_flat;
    logic [M*DW-1:0]       y_flat;

    assign s_ready = (phase_q == PH_LOAD);
    assign accept  = s_valid && s_ready;
    assign vec_end = accept && (s_last || (in_cnt_q == CW'(N - 1)));
    assign upd_we  = (phase_q == PH_UPD);
    assign host_we = wr_en && (phase_q == PH_LOAD) && (in_cnt_q == '0);
    assign done    = done_q;

    gha_weight_store #(.M(M), .N(N), .RW(RW), .CW(CW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (upd_we || host_we),
        .wrow   (upd_we ? i_q : wr_row),
        .wcol   (upd_we ? j_q : wr_col),
        .wdata  (upd_we ? c_new : wr_data),
        .arow   (i_q),
        .acol   (j_q),
        .adata  (c_a),
        .brow   (rd_row),
        .bcol   (rd_col),
        .bdata  (rd_weight),
        .w_flat (w_flat)
    );

    gha_lane_math #(.AW(AW)) u_lane (
        .y_i     (y_q[i_q]),
        .c_old   (c_a),
        .x_j     (x_q[j_q]),
        .sum_in  (sum_q),
        .shift   (shift_q),
        .sum_out (sum_nxt),
        .c_new   (c_new)
    );

    // Multiply-accumulate for the output pass.
    always_comb begin
        mac_prod = (2*DW)'(c_a) * (2*DW)'(x_q[j_q]);
        acc_nxt  = acc_q + AW'(mac_prod);
    end

    // Phase sequencing, loop counters, accumulators and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_LOAD;
            in_cnt_q <= '0;
            i_q      <= '0;
            j_q      <= '0;
            acc_q    <= '0;
            sum_q    <= '0;
            shift_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_LOAD: if (accept) begin
                    if (in_cnt_q == '0) shift_q <= lr_shift;
                    if (vec_end) begin
                        phase_q  <= PH_OUT;
                        in_cnt_q <= '0;
                        i_q      <= '0;
                        j_q      <= '0;
                        acc_q    <= '0;
                    end else begin
                        in_cnt_q <= in_cnt_q + 1'b1;
                    end
                end
                PH_OUT: if (j_q == CW'(N - 1)) begin
                    acc_q <= '0;
                    j_q   <= '0;
                    if (i_q == RW'(M - 1)) begin
                        i_q     <= '0;
                        sum_q   <= '0;
                        phase_q <= PH_UPD;
                    end else begin
                        i_q <= i_q + 1'b1;
                    end
                end else begin
                    acc_q <= acc_nxt;
                    j_q   <= j_q + 1'b1;
                end
                PH_UPD: if (i_q == RW'(M - 1)) begin
                    sum_q <= '0;
                    i_q   <= '0;
                    if (j_q == CW'(N - 1)) begin
                        j_q     <= '0;
                        phase_q <= PH_LOAD;
                        done_q  <= 1'b1;
                    end else begin
                        j_q <= j_q + 1'b1;
                    end
                end else begin
                    sum_q <= sum_nxt;
                    i_q   <= i_q + 1'b1;
                end
                default: phase_q <= PH_LOAD;
            endcase
        end
    end

    // Input vector capture with zero fill after an early last flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) x_q[k] <= '0;
        end else if (accept) begin
            for (int k = 0; k < N; k++) begin
                if (CW'(k) == in_cnt_q)                   x_q[k] <= s_data;
                else if (vec_end && (CW'(k) > in_cnt_q))  x_q[k] <= '0;
            end
        end
    end

    // Output register written at the end of each row of the output pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < M; k++) y_q[k] <= '0;
        end else if (phase_q == PH_OUT && j_q == CW'(N - 1)) begin
            y_q[i_q] <= sat_dw(64'(acc_nxt >>> FRAC));
        end
    end

    // Output readback and flat view for the checker.
    assign y_out = (32'(y_sel) < M) ? y_q[y_sel] : '0;
    for (genvar k = 0; k < M; k++) begin : g_yflat
        assign y_flat[k*DW +: DW] = y_q[k];
    end
endmodule

// File: rtl/gha_engine_chk.sv
`timescale 1ns/1ps
// Protocol and hold checks for gha_engine, attached with bind.
// Watches the stream handshake, the done pulse, the output register and the
// weight matrix.
module gha_engine_chk #(
    parameter int M  = 2,
    parameter int N  = 5,
    parameter int CW = 3,
    parameter int DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic              s_last,
    input logic              done,
    input logic [CW-1:0]     in_cnt,
    input logic [M*DW-1:0]   y_flat,
    input logic [M*N*DW-1:0] w_flat
);
    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> s_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> !s_ready);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(in_cnt) < N);

    // R11
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && $past(s_ready)) |-> $stable(y_flat));

    // R3
    w_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && in_cnt != '0) |=> $stable(w_flat));
endmodule

bind gha_engine gha_engine_chk #(.M(M), .N(N), .CW(CW), .DW(gha_pkg::DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_last  (s_last),
    .done    (done),
    .in_cnt  (in_cnt_q),
    .y_flat  (y_flat),
    .w_flat  (w_flat)
);

// File: tb/gha_engine_bench.sv
`timescale 1ns/1ps
// Self-checking bench for gha_engine against an exact integer model.
module gha_engine_bench;
    import gha_pkg::*;

    localparam int M  = 2;
    localparam int N  = 5;
    localparam int NV = 4;

    // Stimulus table: input vector, elements sent (s_last position), shift.
    localparam logic signed [15:0] VX [NV][N] = '{
        '{16'sd4096,  -16'sd2048, 16'sd1024,  16'sd3000,  -16'sd500},
        '{-16'sd4096, 16'sd4096,  16'sd2000,  -16'sd1000, 16'sd800},
        '{16'sd1500,  16'sd2500,  -16'sd3500, 16'sd7000,  16'sd7000},
        '{16'sd8000,  -16'sd8000, 16'sd6000,  16'sd100,   -16'sd7000}
    };
    localparam int VLEN [NV] = '{5, 5, 3, 5};
    localparam int VSH  [NV] = '{3, 2, 4, 1};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic signed [15:0] s_data = '0;
    logic              s_last = 1'b0;
    logic [3:0]        lr_shift = '0;
    logic              wr_en = 1'b0;
    logic [0:0]        wr_row = '0;
    logic [2:0]        wr_col = '0;
    logic signed [15:0] wr_data = '0;
    logic [0:0]        rd_row = '0;
    logic [2:0]        rd_col = '0;
    logic signed [15:0] rd_weight;
    logic [0:0]        y_sel = '0;
    logic signed [15:0] y_out;
    logic              done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    longint mw [M][N];
    longint my [M];

    gha_engine u_gha_engine (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .lr_shift(lr_shift),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .rd_row(rd_row), .rd_col(rd_col), .rd_weight(rd_weight),
        .y_sel(y_sel), .y_out(y_out), .done(done)
    );

    always #10 clk = ~clk;

    task automatic check_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Exact reference of one training step on mw/my.
    task automatic model_step(input longint xv[N], input int sh);
        longint acc, s, e, d;
        for (int i = 0; i < M; i++) begin
            acc = 0;
            for (int j = 0; j < N; j++) acc += mw[i][j] * xv[j];
            my[i] = sat(acc >>> 12);
        end
        for (int j = 0; j < N; j++) begin
            s = 0;
            for (int i = 0; i < M; i++) begin
                s += my[i] * mw[i][j];
                e = sat(((xv[j] <<< 12) - s) >>> 12);
                d = (my[i] * e) >>> (12 + sh);
                mw[i][j] = sat(mw[i][j] + d);
            end
        end
    endtask

    task automatic write_w(input int r, input int c, input longint v);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 1'(r); wr_col = 3'(c); wr_data = 16'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic compare_all(input string tag_y, input string tag_w);
        for (int i = 0; i < M; i++) begin
            y_sel = 1'(i); #1;
            check_eq(tag_y, y_out, my[i]);
        end
        for (int r = 0; r < M; r++)
            for (int c = 0; c < N; c++) begin
                rd_row = 1'(r); rd_col = 3'(c); #1;
                check_eq(tag_w, rd_weight, mw[r][c]);
            end
    endtask

    // Stream one vector; optionally poke ignored writes mid-vector and while busy.
    task automatic send_vec(input longint xv[N], input int len, input int sh, input bit poke);
        bit got;
        for (int e = 0; e < len; e++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = 16'(xv[e]); s_last = (e == len - 1);
            lr_shift = (e == 0) ? 4'(sh) : 4'hF;
            wr_en = poke && (e == 1);
            wr_row = '0; wr_col = '0; wr_data = 16'sh1234;
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        check_eq("R4 s_ready low after last", s_ready, 0);
        wr_en = poke;
        got = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (done) begin got = 1; break; end
        end
        check_eq("R10 done seen", got, 1);
        check_eq("R10 ready with done", s_ready, 1);
        @(negedge clk);
        check_eq("R10 done single cycle", done, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        longint xv [N];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 s_ready", s_ready, 1);
        check_eq("R1 done", done, 0);
        for (int i = 0; i < M; i++) my[i] = 0;
        for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) mw[r][c] = 0;
        compare_all("R1 y reset", "R1 weight reset");

        // R2 initial load
        for (int r = 0; r < M; r++)
            for (int c = 0; c < N; c++) begin
                mw[r][c] = ((r*N + c) % 2 == 1) ? -(300 + r*97 + c*53) : (300 + r*97 + c*53);
                write_w(r, c, mw[r][c]);
            end
        compare_all("R2 y idle", "R2 weight load");

        // Table walk: R3 R5 R6 R7 R8 R11
        for (int v = 0; v < NV; v++) begin
            for (int j = 0; j < N; j++) xv[j] = (j < VLEN[v]) ? longint'(VX[v][j]) : 0;
            send_vec(xv, VLEN[v], VSH[v], 1'b1);
            model_step(xv, VSH[v]);
            compare_all((VLEN[v] < N) ? "R5 R6 y" : "R6 R11 y",
                        (VLEN[v] < N) ? "R5 R7 weight" : "R3 R7 R8 weight");
        end

        // R9 saturation of outputs and weights
        for (int r = 0; r < M; r++)
            for (int c = 0; c < N; c++) begin
                mw[r][c] = 28672;
                write_w(r, c, 28672);
            end
        for (int j = 0; j < N; j++) xv[j] = 32767;
        send_vec(xv, N, 0, 1'b0);
        model_step(xv, 0);
        y_sel = '0; #1;
        check_eq("R9 y saturates", y_out, 32767);
        rd_row = '0; rd_col = '0; #1;
        check_eq("R9 weight saturates", rd_weight, -32768);
        compare_all("R9 y", "R9 weight");

        // R1 reset during computation
        @(negedge clk);
        s_valid = 1'b1; s_data = 16'sd4096; s_last = 1'b1; lr_shift = 4'd1;
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 s_ready after mid reset", s_ready, 1);
        for (int i = 0; i < M; i++) my[i] = 0;
        for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) mw[r][c] = 0;
        compare_all("R1 y mid reset", "R1 weight mid reset");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule